// File: doc/BRIEF.md
# Frame-Tagged Output FIFO

This block buffers rendered output between a producer and a host reader. Each entry is a 32-bit double-word with one extra bit that the producer raises on the final word of a frame. The buffer holds up to 64 entries. The reader sees the oldest entry on its read port without delay, and a read strobe removes that entry.

Besides its data, the block reports three things. It gives a readable count, saturated to a 6-bit field. It gives a 2-bit state code that separates empty, partly filled and full. It also raises a flag whenever a frame-ending word sits among the stored entries, so the reader knows that draining the counted words completes a frame. Interrupt generation and register access are left to surrounding logic.

Top module: `tagged_out_fifo`

## Requirements
- R1: While reset is asserted, and on the first sample after it, the FIFO is empty: `level` is 0, `fifo_state` is 2'b00 and `frame_in_window` is 0.
- R2: Words leave in the order they were accepted, and each keeps its tag. `rd_data` and `rd_last` show the oldest stored entry whenever the FIFO is not empty, and they stay unchanged until that entry is read.
- R3: A write strobe while the FIFO holds 64 entries is dropped. The stored contents, the count and the state do not change.
- R4: A read strobe while the FIFO is empty is ignored. The FIFO stays empty with `level` 0.
- R5: For 0 to 63 stored entries, `level` equals the number stored. With 64 stored entries it saturates at 6'h3F.
- R6: `fifo_state` is 2'b00 when empty, 2'b11 when 64 entries are stored and 2'b01 otherwise. The code 2'b10 never appears.
- R7: `frame_in_window` is 1 exactly when at least one stored entry was written with `wr_last` set.
- R8: When a read and a write are both accepted in the same cycle, the stored count is unchanged. The head advances to the next word, and the new word goes to the tail.
- R9: With both strobes high, a full FIFO accepts only the read and an empty FIFO accepts only the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low; empties the FIFO |
| wr_en | input | 1 | Producer write strobe |
| wr_data | input | 32 | Producer double-word |
| wr_last | input | 1 | Tag: this word ends a frame |
| rd_en | input | 1 | Reader strobe; removes the head entry |
| rd_data | output | 32 | Head entry data |
| rd_last | output | 1 | Head entry tag |
| level | output | 6 | Readable count, saturated at 6'h3F |
| fifo_state | output | 2 | 00 empty, 01 data readable, 11 full |
| frame_in_window | output | 1 | A frame-ending word is among the stored entries |

## Verification
The hardest case to reach from the ports is a completely full FIFO that still holds tagged words while both strobes arrive together. Only there does the write get dropped while the read goes through, and only there can the tag counter go wrong. The stimulus fills the buffer with a directed run of 70 writes, with tags mixed in, and then issues simultaneous strobes at the full and empty extremes. After that, random phases with a fixed seed lean toward writing or toward reading, which brings the count back to both ends many times.

// File: rtl/tagged_fifo_pkg.sv
package tagged_fifo_pkg;
   typedef enum logic [1:0] {
      ST_EMPTY = 2'b00,
      ST_READY = 2'b01,
      ST_FULL  = 2'b11
   } fifo_state_e;
endpackage

// File: rtl/fifo_ptr_ctrl.sv
module fifo_ptr_ctrl #(
   parameter int DEPTH = 64,
   localparam int AW    = $clog2(DEPTH),
   localparam int OCC_W = AW + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_req,
   input  logic             rd_req,
   output logic             wr_acc,
   output logic             rd_acc,
   output logic [AW-1:0]    wr_addr,
   output logic [AW-1:0]    rd_addr,
   output logic [OCC_W-1:0] occ
);
   localparam logic [OCC_W-1:0] FULL_OCC = OCC_W'(DEPTH);

   logic [AW-1:0]    wp_q, rp_q;
   logic [OCC_W-1:0] occ_q;
   logic             is_full, is_empty;

   assign is_full  = (occ_q == FULL_OCC);
   assign is_empty = (occ_q == '0);
   assign wr_acc   = wr_req && !is_full;
   assign rd_acc   = rd_req && !is_empty;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp_q  <= '0;
         rp_q  <= '0;
         occ_q <= '0;
      end else begin
         if (wr_acc) wp_q <= wp_q + 1'b1;
         if (rd_acc) rp_q <= rp_q + 1'b1;
         case ({wr_acc, rd_acc})
            2'b10:   occ_q <= occ_q + 1'b1;
            2'b01:   occ_q <= occ_q - 1'b1;
            default: occ_q <= occ_q;
         endcase
      end
   end

   assign wr_addr = wp_q;
   assign rd_addr = rp_q;
   assign occ     = occ_q;
endmodule

// File: rtl/fifo_store.sv
module fifo_store #(
   parameter int WIDTH = 33,
   parameter int DEPTH = 64,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             we,
   input  logic [AW-1:0]    waddr,
   input  logic [WIDTH-1:0] wdata,
   input  logic [AW-1:0]    raddr,
   output logic [WIDTH-1:0] rdata
);
   logic [WIDTH-1:0] cells [DEPTH];

   for (genvar gi = 0; gi < DEPTH; gi++) begin : g_row
      always_ff @(posedge clk) begin
         if (we && (waddr == AW'(gi))) cells[gi] <= wdata;
      end
   end

   assign rdata = cells[raddr];
endmodule

// File: rtl/fifo_tag_track.sv
module fifo_tag_track #(
   parameter int DEPTH = 64,
   localparam int TW   = $clog2(DEPTH) + 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tag_in,
   input  logic tag_out,
   output logic any_tag
);
   logic [TW-1:0] tcnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tcnt_q <= '0;
      end else begin
         case ({tag_in, tag_out})
            2'b10:   tcnt_q <= tcnt_q + 1'b1;
            2'b01:   tcnt_q <= tcnt_q - 1'b1;
            default: tcnt_q <= tcnt_q;
         endcase
      end
   end

   assign any_tag = (tcnt_q != '0);
endmodule

// File: rtl/fifo_status_enc.sv
module fifo_status_enc
   import tagged_fifo_pkg::*;
#(
   parameter int DEPTH = 64,
   parameter int CNT_W = 6,
   localparam int OCC_W = $clog2(DEPTH) + 1
) (
   input  logic [OCC_W-1:0] occ,
   output logic [CNT_W-1:0] level,
   output fifo_state_e      state
);
   localparam logic [OCC_W-1:0] FULL_OCC = OCC_W'(DEPTH);

   if (CNT_W >= OCC_W) begin : g_wide
      assign level = CNT_W'(occ);
   end else begin : g_sat
      localparam logic [OCC_W-1:0] CNT_MAX = OCC_W'((1 << CNT_W) - 1);
      assign level = (occ > CNT_MAX) ? '1 : occ[CNT_W-1:0];
   end

   always_comb begin
      if (occ == '0)            state = ST_EMPTY;
      else if (occ == FULL_OCC) state = ST_FULL;
      else                      state = ST_READY;
   end
endmodule

// File: rtl/tagged_out_fifo.sv
module tagged_out_fifo
   import tagged_fifo_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int DEPTH  = 64,
   parameter int CNT_W  = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              wr_last,
   input  logic              rd_en,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_last,
   output logic [CNT_W-1:0]  level,
   output logic [1:0]        fifo_state,
   output logic              frame_in_window
);
   localparam int AW    = $clog2(DEPTH);
   localparam int OCC_W = AW + 1;
   localparam int ENT_W = DATA_W + 1;

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("tagged_out_fifo: DEPTH must be a power of two, at least 2");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("tagged_out_fifo: DATA_W must be positive");
   end
   if (CNT_W < 1) begin : g_bad_cnt
      $error("tagged_out_fifo: CNT_W must be positive");
   end

   logic             wr_acc, rd_acc;
   logic [AW-1:0]    wr_addr, rd_addr;
   logic [OCC_W-1:0] occ;
   logic [ENT_W-1:0] head;
   fifo_state_e      st;

   fifo_ptr_ctrl #(.DEPTH(DEPTH)) i_ptr (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_req  (wr_en),
      .rd_req  (rd_en),
      .wr_acc  (wr_acc),
      .rd_acc  (rd_acc),
      .wr_addr (wr_addr),
      .rd_addr (rd_addr),
      .occ     (occ)
   );

   fifo_store #(.WIDTH(ENT_W), .DEPTH(DEPTH)) i_store (
      .clk   (clk),
      .we    (wr_acc),
      .waddr (wr_addr),
      .wdata ({wr_last, wr_data}),
      .raddr (rd_addr),
      .rdata (head)
   );

   fifo_tag_track #(.DEPTH(DEPTH)) i_tags (
      .clk     (clk),
      .rst_n   (rst_n),
      .tag_in  (wr_acc && wr_last),
      .tag_out (rd_acc && head[DATA_W]),
      .any_tag (frame_in_window)
   );

   fifo_status_enc #(.DEPTH(DEPTH), .CNT_W(CNT_W)) i_stat (
      .occ   (occ),
      .level (level),
      .state (st)
   );

   assign rd_data    = head[DATA_W-1:0];
   assign rd_last    = head[DATA_W];
   assign fifo_state = st;
endmodule

// File: rtl/tagged_out_fifo_chk.sv
module tagged_out_fifo_chk #(
   parameter int DATA_W = 32,
   parameter int CNT_W  = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic              rd_en,
   input logic [DATA_W-1:0] rd_data,
   input logic [CNT_W-1:0]  level,
   input logic [1:0]        fifo_state,
   input logic              frame_in_window
);
   localparam logic [1:0] S_EMPTY = 2'b00;
   localparam logic [1:0] S_READY = 2'b01;
   localparam logic [1:0] S_FULL  = 2'b11;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         p_reset_empty_r1: assert (fifo_state == S_EMPTY && level == '0 && !frame_in_window)
            else $error("R1: FIFO not empty during reset");
      end
   end

   p_head_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_state != S_EMPTY && !rd_en) |=> $stable(rd_data))
      else $error("R2: head word changed without a read");

   p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_state == S_FULL && wr_en && !rd_en) |=> (fifo_state == S_FULL && $stable(level)))
      else $error("R3: write while full changed state");

   p_no_underflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_state == S_EMPTY && rd_en && !wr_en) |=> (fifo_state == S_EMPTY && level == '0))
      else $error("R4: read while empty changed state");

   p_level_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_state == S_READY && wr_en && !rd_en && level != '1) |=> (level == $past(level) + 1'b1))
      else $error("R5: level did not step on a write");

   p_state_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_state != 2'b10)
      else $error("R6: illegal state code");

   p_empty_no_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_state == S_EMPTY) |-> (!frame_in_window && level == '0))
      else $error("R7: flag or level set while empty");

   p_rw_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_state == S_READY && wr_en && rd_en) |=> (fifo_state == S_READY && $stable(level)))
      else $error("R8: simultaneous access changed level");

   p_full_both_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_state == S_FULL && wr_en && rd_en) |=> (fifo_state == S_READY && level == '1))
      else $error("R9: full with both strobes mishandled");
endmodule

bind tagged_out_fifo tagged_out_fifo_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) i_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .wr_en           (wr_en),
   .rd_en           (rd_en),
   .rd_data         (rd_data),
   .level           (level),
   .fifo_state      (fifo_state),
   .frame_in_window (frame_in_window)
);

// File: tb/test_tagged_out_fifo.sv
module test_tagged_out_fifo;
   localparam int DW = 32;
   localparam int DEPTH = 64;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0, wr_last = 1'b0, rd_en = 1'b0;
   logic [DW-1:0] wr_data = '0;
   logic [DW-1:0] rd_data;
   logic          rd_last;
   logic [5:0]    level;
   logic [1:0]    fifo_state;
   logic          frame_in_window;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   logic [DW:0] model[$];

   always #10 clk = ~clk;

   tagged_out_fifo i_tagged_out_fifo (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .wr_last(wr_last),
      .rd_en(rd_en), .rd_data(rd_data), .rd_last(rd_last), .level(level),
      .fifo_state(fifo_state), .frame_in_window(frame_in_window)
   );

   function automatic logic [5:0] exp_level(int n);
      return (n >= 63) ? 6'h3F : 6'(n);
   endfunction

   function automatic logic [1:0] exp_state(int n);
      if (n == 0) return 2'b00;
      if (n == DEPTH) return 2'b11;
      return 2'b01;
   endfunction

   function automatic logic exp_flag();
      foreach (model[i]) if (model[i][DW]) return 1'b1;
      return 1'b0;
   endfunction

   task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic check_all();
      int n = model.size();
      chk("R5 level", 64'(level), 64'(exp_level(n)));
      chk("R6 state", 64'(fifo_state), 64'(exp_state(n)));
      chk("R7 frame flag", 64'(frame_in_window), 64'(exp_flag()));
      if (n > 0) begin
         chk("R2 head data", 64'(rd_data), 64'(model[0][DW-1:0]));
         chk("R2 head tag", 64'(rd_last), 64'(model[0][DW]));
      end
   endtask

   // Called at a falling edge: drive, take the rising edge, update model, sample at next falling edge.
   task automatic step(bit w, logic [DW-1:0] d, bit l, bit r);
      int n;
      bit wa, ra;
      wr_en = w; wr_data = d; wr_last = l; rd_en = r;
      @(posedge clk);
      n = model.size();
      wa = w && (n < DEPTH);
      ra = r && (n > 0);
      if (ra) void'(model.pop_front());
      if (wa) model.push_back({l, d});
      @(negedge clk);
      wr_en = 1'b0; rd_en = 1'b0;
      check_all();
   endtask

   initial begin
      #(20 * 200000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int n0;
      void'($urandom(32'h5EED_1234));
      repeat (3) @(negedge clk);
      chk("R1 reset level", 64'(level), 64'd0);
      chk("R1 reset state", 64'(fifo_state), 64'd0);
      chk("R1 reset flag", 64'(frame_in_window), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check_all();

      // R4: reads on an empty FIFO
      repeat (3) step(0, '0, 0, 1);

      // R9: both strobes while empty -> only write accepted
      step(1, 32'hA5A5_0001, 1, 1);
      chk("R9 empty both level", 64'(level), 64'd1);
      step(0, '0, 0, 1);

      // R3/R5/R6: fill past full, tag every ninth word
      for (int i = 0; i < 70; i++) step(1, 32'h1000_0000 + i, (i % 9) == 8, 0);
      chk("R3 full state kept", 64'(fifo_state), 64'd3);
      chk("R5 saturated level", 64'(level), 64'h3F);

      // R9: both strobes while full -> only read accepted
      step(1, 32'hDEAD_BEEF, 1, 1);
      chk("R9 full both level", 64'(level), 64'h3F);
      chk("R9 full both state", 64'(fifo_state), 64'd1);

      // R8: simultaneous at mid level
      for (int i = 0; i < 30; i++) step(0, '0, 0, 1);
      n0 = model.size();
      for (int i = 0; i < 10; i++) step(1, 32'h2000_0000 + i, i == 4, 1);
      chk("R8 level kept", 64'(level), 64'(exp_level(n0)));

      // drain with extra reads (R4)
      repeat (70) step(0, '0, 0, 1);
      chk("R4 empty after drain", 64'(fifo_state), 64'd0);

      // random phases biased toward filling or draining
      for (int ph = 0; ph < 40; ph++) begin
         int wp = (ph % 2 == 0) ? 80 : 25;
         int rp = (ph % 2 == 0) ? 25 : 80;
         for (int k = 0; k < 100; k++) begin
            bit w = ($urandom % 100) < wp;
            bit r = ($urandom % 100) < rp;
            bit l = ($urandom % 6) == 0;
            step(w, $urandom, l, r);
         end
      end

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule